// File: doc/BRIEF.md
# Banked Multi-Port Shared Memory

This block is a shared on-chip word memory that many requesters use at once. The word address space is cut into a power-of-two number of banks. Each bank is a two-port RAM. A crossbar sends every request to the bank named by the low bits of its word address. The default build has twelve request ports, four banks and 32-bit words. Its capacity is set by parameters, so the full 32 KB build uses a wider address.

Each bank has its own arbiter, and the arbiters run independently of one another. Each cycle a bank serves at most two requests, one on each RAM port. A requester that loses sees its ready signal low. It must hold the same request, with valid asserted, until ready comes back high. Losing stalls the requester but never drops its access. The arbiter's scan start point rotates round-robin per bank, so every waiting port is served within a bounded number of cycles. A read returns its data one cycle after it is accepted, on the same port that issued it.

Top module: `banked_mem`

## Requirements
- R1: The bank of a request is the low BANK_W bits of its word address, and the row inside the bank is the remaining upper bits. A word written at an address is returned by a later read of that same address.
- R2: A bank with one or two valid requests in a cycle raises ready on all of them in that cycle. Banks work independently, so up to two requests per bank are accepted in the same cycle.
- R3: A request beyond the second to one bank in a cycle sees ready low. That request has no effect: it writes nothing and produces no response. Ready is never high without valid.
- R4: Each bank scans the ports starting at its pointer, in increasing port number, wrapping from the last port to port 0. The first valid request found for the bank is granted RAM port A and the second is granted RAM port B. After a cycle with grants, the pointer moves to one past the last port granted.
- R5: A read accepted in cycle t raises rsp_valid and presents rsp_rdata on the same port in cycle t+1. An accepted write raises no rsp_valid.
- R6: Two writes granted in one cycle to the same address leave the data of the port-A grantee, which is the earlier port in scan order.
- R7: A read accepted in the same cycle as a write to the same address returns the data held before that write.
- R8: Reset clears rsp_valid and sets every bank pointer to port 0. Ready stays low while no request is valid.
- R9: A request held valid is granted after waiting at most N_PORTS-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_we | input | N_PORTS | 1 = write, 0 = read, one bit per port |
| req_addr | input | N_PORTS*ADDR_W | Word address; port p uses bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | N_PORTS*DATA_W | Write data; port p uses bits [p*DATA_W +: DATA_W] |
| req_ready | output | N_PORTS | Request accepted this cycle |
| rsp_valid | output | N_PORTS | Read data valid, one cycle after the accepted read |
| rsp_rdata | output | N_PORTS*DATA_W | Read data; port p uses bits [p*DATA_W +: DATA_W] |

## Verification
The bench drives all twelve ports at one bank together. A wrong scan order or a pointer that never moves would show up as the wrong pair of ready bits, or as a port whose wait grows past eleven cycles. Traffic confined to sixteen addresses forces third-requester collisions, same-address double writes and read-write collisions. A design that let a stalled write through, let port B win a double write, or forwarded new data to a colliding read would later return a word that differs from the reference memory. Response timing is compared every cycle, which catches a response that is late, missing, or raised for a write.

// File: rtl/banked_mem.sv
module banked_mem #(
  parameter int N_PORTS = 12,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 11,
  parameter int BANK_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          req_valid,
  input  logic [N_PORTS-1:0]          req_we,
  input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
  input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
  output logic [N_PORTS-1:0]          req_ready,
  output logic [N_PORTS-1:0]          rsp_valid,
  output logic [N_PORTS*DATA_W-1:0]   rsp_rdata
);
  localparam int NB    = 1 << BANK_W;
  localparam int ROW_W = ADDR_W - BANK_W;
  localparam int DEPTH = 1 << ROW_W;
  localparam int PW    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [ADDR_W-1:0] addr [N_PORTS];
  logic [DATA_W-1:0] wdat [N_PORTS];
  logic [PW-1:0]     ptr  [NB];
  logic [PW-1:0]     g_a  [NB];
  logic [PW-1:0]     g_b  [NB];
  logic [NB-1:0]     ga_v, gb_v;
  logic [N_PORTS-1:0] on_b;
  logic [N_PORTS-1:0] want [NB];

  logic [DATA_W-1:0] mem [NB][DEPTH];
  logic [DATA_W-1:0] q_a [NB];
  logic [DATA_W-1:0] q_b [NB];

  logic [BANK_W-1:0] r_bank [N_PORTS];
  logic [N_PORTS-1:0] r_side;

  function automatic logic [PW-1:0] after(input logic [PW-1:0] i);
    return (int'(i) == N_PORTS - 1) ? '0 : i + 1'b1;
  endfunction

  for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
    assign addr[p] = req_addr[p*ADDR_W +: ADDR_W];
    assign wdat[p] = req_wdata[p*DATA_W +: DATA_W];
  end

  // Request decode per bank (used for checking, independent of the scan)
  always_comb begin
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < N_PORTS; p++)
        want[b][p] = req_valid[p] && (int'(addr[p][BANK_W-1:0]) == b);
  end

  // Rotating two-grant scan per bank
  always_comb begin
    int idx;
    for (int b = 0; b < NB; b++) begin
      ga_v[b] = 1'b0;
      gb_v[b] = 1'b0;
      g_a[b]  = '0;
      g_b[b]  = '0;
      for (int k = 0; k < N_PORTS; k++) begin
        idx = int'(ptr[b]) + k;
        if (idx >= N_PORTS) idx = idx - N_PORTS;
        if (req_valid[idx] && int'(addr[idx][BANK_W-1:0]) == b) begin
          if (!ga_v[b]) begin
            ga_v[b] = 1'b1;
            g_a[b]  = PW'(idx);
          end else if (!gb_v[b]) begin
            gb_v[b] = 1'b1;
            g_b[b]  = PW'(idx);
          end
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      req_ready[p] = 1'b0;
      on_b[p]      = 1'b0;
      for (int b = 0; b < NB; b++) begin
        if (ga_v[b] && g_a[b] == PW'(p)) req_ready[p] = 1'b1;
        if (gb_v[b] && g_b[b] == PW'(p)) begin
          req_ready[p] = 1'b1;
          on_b[p]      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) ptr[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (gb_v[b])      ptr[b] <= after(g_b[b]);
        else if (ga_v[b]) ptr[b] <= after(g_a[b]);
      end
    end
  end

  // Two-port banks: B writes first so a same-address A write lands last
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (gb_v[b]) begin
        q_b[b] <= mem[b][addr[g_b[b]][ADDR_W-1:BANK_W]];
        if (req_we[g_b[b]]) mem[b][addr[g_b[b]][ADDR_W-1:BANK_W]] <= wdat[g_b[b]];
      end
      if (ga_v[b]) begin
        q_a[b] <= mem[b][addr[g_a[b]][ADDR_W-1:BANK_W]];
        if (req_we[g_a[b]]) mem[b][addr[g_a[b]][ADDR_W-1:BANK_W]] <= wdat[g_a[b]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      r_side    <= '0;
      for (int p = 0; p < N_PORTS; p++) r_bank[p] <= '0;
    end else begin
      rsp_valid <= req_valid & req_ready & ~req_we;
      r_side    <= on_b;
      for (int p = 0; p < N_PORTS; p++) r_bank[p] <= addr[p][BANK_W-1:0];
    end
  end

  always_comb begin
    for (int p = 0; p < N_PORTS; p++)
      rsp_rdata[p*DATA_W +: DATA_W] = r_side[p] ? q_b[r_bank[p]] : q_a[r_bank[p]];
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
    a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |-> req_valid[p]);
    a_r5_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_ready[p] && !req_we[p]) |=> rsp_valid[p]);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(req_valid[p] && req_ready[p] && !req_we[p]));
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    a_r2_two_served: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_ready & want[b]) ==
        (($countones(want[b]) > 2) ? 2 : $countones(want[b])));
  end
endmodule

// File: tb/banked_mem_tb.sv
module banked_mem_tb;
  localparam int CLK_P = 10;
  localparam int N   = 12;
  localparam int DW  = 32;
  localparam int AW  = 11;
  localparam int BW  = 2;
  localparam int NBK = 1 << BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_valid, req_we, req_ready, rsp_valid;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata, rsp_rdata;

  banked_mem #(.N_PORTS(N), .DATA_W(DW), .ADDR_W(AW), .BANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int mode = 3;
  bit pv[N]; bit pwe[N]; int paddr[N]; logic [DW-1:0] pwd[N];
  int waitc[N];
  int ptr_m[NBK];
  logic [DW-1:0] mem_m [int];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    for (int p = 0; p < N; p++) begin
      req_valid[p] = pv[p];
      req_we[p]    = pwe[p];
      req_addr[p*AW +: AW]  = AW'(paddr[p]);
      req_wdata[p*DW +: DW] = pwd[p];
    end
  endtask

  task automatic renew(input int p);
    case (mode)
      1: begin pv[p] = ($urandom % 4) != 0; pwe[p] = $urandom % 2; paddr[p] = $urandom % 16; pwd[p] = $urandom; end
      2: begin pv[p] = ($urandom % 3) != 0; pwe[p] = $urandom % 2; paddr[p] = $urandom % (1 << AW); pwd[p] = $urandom; end
      default: pv[p] = 1'b0;
    endcase
  endtask

  task automatic cycle();
    bit er[N]; bit erv[N]; bit ekn[N]; logic [DW-1:0] erd[N];
    int g0[NBK]; int g1[NBK]; int cnt, p;
    drive();
    #1;
    for (int q = 0; q < N; q++) begin er[q] = 0; erv[q] = 0; ekn[q] = 0; erd[q] = '0; end
    for (int b = 0; b < NBK; b++) begin
      cnt = 0; g0[b] = -1; g1[b] = -1;
      for (int k = 0; k < N; k++) begin
        p = (ptr_m[b] + k) % N;
        if (pv[p] && (paddr[p] % NBK) == b) begin
          if (cnt == 0) g0[b] = p; else if (cnt == 1) g1[b] = p;
          cnt++;
        end
      end
      if (g1[b] >= 0) ptr_m[b] = (g1[b] + 1) % N;
      else if (g0[b] >= 0) ptr_m[b] = (g0[b] + 1) % N;
      if (g0[b] >= 0) er[g0[b]] = 1;
      if (g1[b] >= 0) er[g1[b]] = 1;
    end
    for (int q = 0; q < N; q++) begin
      chk(req_ready[q] == er[q], $sformatf("R2 R3 R4 ready port %0d", q), DW'(req_ready[q]), DW'(er[q]));
      if (pv[q] && !er[q]) begin
        waitc[q]++;
        chk(waitc[q] <= N - 1, $sformatf("R9 wait port %0d", q), DW'(waitc[q]), DW'(N - 1));
      end else waitc[q] = 0;
      erv[q] = er[q] && !pwe[q];
      if (erv[q] && mem_m.exists(paddr[q])) begin ekn[q] = 1; erd[q] = mem_m[paddr[q]]; end
    end
    for (int b = 0; b < NBK; b++) begin
      if (g1[b] >= 0 && pwe[g1[b]]) mem_m[paddr[g1[b]]] = pwd[g1[b]];
      if (g0[b] >= 0 && pwe[g0[b]]) mem_m[paddr[g0[b]]] = pwd[g0[b]];
    end
    @(posedge clk);
    #1;
    for (int q = 0; q < N; q++) begin
      chk(rsp_valid[q] == erv[q], $sformatf("R5 rsp_valid port %0d", q), DW'(rsp_valid[q]), DW'(erv[q]));
      if (ekn[q])
        chk(rsp_rdata[q*DW +: DW] === erd[q], $sformatf("R1 R6 R7 rdata port %0d", q), rsp_rdata[q*DW +: DW], erd[q]);
    end
    for (int q = 0; q < N; q++) if (er[q]) renew(q);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      nerr++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < N; p++) begin pv[p] = 0; pwe[p] = 0; paddr[p] = 0; pwd[p] = '0; waitc[p] = 0; end
    for (int b = 0; b < NBK; b++) ptr_m[b] = 0;
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, "R8 reset rsp_valid", DW'(rsp_valid), '0);
    chk(req_ready == '0, "R8 idle ready", DW'(req_ready), '0);

    // All ports write bank 0, distinct rows
    mode = 3;
    for (int p = 0; p < N; p++) begin pv[p] = 1; pwe[p] = 1; paddr[p] = p * NBK; pwd[p] = 32'hA000 + p; end
    repeat (8) cycle();
    // All ports read them back
    for (int p = 0; p < N; p++) begin pv[p] = 1; pwe[p] = 0; paddr[p] = ((p + 5) % N) * NBK; end
    repeat (8) cycle();
    // Spread across banks: two per bank
    for (int p = 0; p < 8; p++) begin pv[p] = 1; pwe[p] = p[0]; paddr[p] = p + 64; pwd[p] = 32'hB000 + p; end
    repeat (3) cycle();

    mode = 1;
    for (int p = 0; p < N; p++) renew(p);
    repeat (3000) cycle();
    mode = 2;
    for (int p = 0; p < N; p++) renew(p);
    repeat (3000) cycle();
    mode = 1;
    for (int p = 0; p < N; p++) renew(p);
    repeat (2000) cycle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule